// File: doc/BRIEF.md
# Counted Byte Copy Engine

This block moves a run of bytes from one memory region to another on behalf of a small processor core. A one-cycle start pulse hands it a source pointer, a destination pointer, a byte count and a width select. The width select chooses between a short count, formed from the low 8 bits of the count input, and a long count that uses all 16 bits. The engine then walks the region one byte at a time. Each byte takes a read phase on the memory port, which waits for the memory to return data, and then a write phase that stores the byte at the destination.

When the count is exhausted, the engine raises a one-cycle completion pulse and a write-back strobe. In that same cycle it presents the advanced source and destination pointers and the spent count, so the caller can update its architectural registers. A count of zero skips the memory entirely and completes immediately. Pointers roll over silently at the top of the 32-bit address space.

Top module: `mcopy_engine`

## Requirements
- R1: When `wide_i` is 0, only `cnt_i[7:0]` sets the number of bytes moved and `cnt_i[15:8]` has no effect. When `wide_i` is 1, all 16 bits of `cnt_i` set it.
- R2: If the selected count is zero when a start is accepted, no read or write takes place, and `done_o` is high in the cycle right after the accepting clock edge.
- R3: Each byte is read from the current source pointer and the same value is then written to the current destination pointer. `rd_req_o` and `wr_en_o` are never high in the same cycle.
- R4: After every byte written, the source and destination pointers each advance by one, wrapping modulo 2^32.
- R5: Exactly the selected number of bytes are read and written, and the reported final count is zero.
- R6: `done_o` and `wb_o` are high for exactly one cycle, the cycle after the last write. In that cycle `src_fin_o` and `dst_fin_o` equal the start pointers plus the byte count, modulo 2^32.
- R7: While `rd_req_o` is high and `rd_valid_i` is low, the engine holds the request and the read address. It leaves the read phase only on `rd_valid_i`.
- R8: `busy_o` is high from the cycle after an accepted start through the completion cycle. A start pulse while `busy_o` is high is ignored.
- R9: A synchronous active-high `rst` returns the engine to idle, with `busy_o`, `done_o`, `rd_req_o` and `wr_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| wide_i | input | 1 | 1: 16-bit count, 0: 8-bit count |
| src_i | input | 32 | Source start pointer |
| dst_i | input | 32 | Destination start pointer |
| cnt_i | input | 16 | Byte count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_o | output | 1 | One-cycle write-back strobe for final values |
| src_fin_o | output | 32 | Final source pointer |
| dst_fin_o | output | 32 | Final destination pointer |
| cnt_fin_o | output | 16 | Final count (zero) |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data |
| wr_en_o | output | 1 | Write enable |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 8 | Write data |

## Verification
The bench starts a short-count copy whose upper count byte is nonzero. An engine that honoured all 16 bits would move 259 bytes instead of 3. It also starts a short-count zero whose upper byte is set. An engine that ignored the width select here would start copying instead of completing in the next cycle. A source run that straddles address 0xFFFFFFFF catches pointers that saturate or fault instead of wrapping. Read latencies of one and two cycles catch a phase machine that writes stale data before the memory answers. A second start issued mid-transfer must leave the byte count and final pointers untouched, and a reset during a transfer must drop every strobe at once.

// File: rtl/mcopy_pkg.sv
package mcopy_pkg;

  typedef enum logic [1:0] {
    MC_IDLE  = 2'd0,
    MC_READ  = 2'd1,
    MC_WRITE = 2'd2,
    MC_DONE  = 2'd3
  } mc_state_e;

endpackage

// File: rtl/mcopy_fsm.sv
module mcopy_fsm
  import mcopy_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      zero_cnt_i,
  input  logic      last_i,
  input  logic      rd_valid_i,
  output mc_state_e state_o,
  output logic      accept_o,
  output logic      capture_o,
  output logic      step_o,
  output logic      finish_o
);

  mc_state_e state_q, state_d;

  assign accept_o  = start_i && (state_q == MC_IDLE);
  assign capture_o = (state_q == MC_READ) && rd_valid_i;
  assign step_o    = (state_q == MC_WRITE);
  assign finish_o  = (state_q == MC_DONE);
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MC_IDLE:  if (accept_o) state_d = zero_cnt_i ? MC_DONE : MC_READ;
      MC_READ:  if (rd_valid_i) state_d = MC_WRITE;
      MC_WRITE: state_d = last_i ? MC_DONE : MC_READ;
      MC_DONE:  state_d = MC_IDLE;
      default:  state_d = MC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MC_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/mcopy_datapath.sv
module mcopy_datapath #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              step_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] src_q_o,
  output logic [ADDR_W-1:0] dst_q_o,
  output logic [CNT_W-1:0]  cnt_q_o,
  output logic [DATA_W-1:0] data_q_o,
  output logic              zero_cnt_o,
  output logic              last_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [ADDR_W-1:0] ptr_advance(input logic [ADDR_W-1:0] p);
    return ADDR_W'(p + ADDR_W'(1));
  endfunction

  function automatic logic [CNT_W-1:0] cnt_retire(input logic [CNT_W-1:0] c);
    return CNT_W'(c - CNT_ONE);
  endfunction

  logic [CNT_W-1:0] narrow_cnt;
  logic [CNT_W-1:0] sel_cnt;

  generate
    if (NARROW_W < CNT_W) begin : g_mask
      assign narrow_cnt = {{(CNT_W-NARROW_W){1'b0}}, cnt_i[NARROW_W-1:0]};
    end else begin : g_full
      assign narrow_cnt = cnt_i;
    end
  endgenerate

  assign sel_cnt    = wide_i ? cnt_i : narrow_cnt;
  assign zero_cnt_o = (sel_cnt == '0);
  assign last_o     = (cnt_q_o == CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q_o  <= '0;
      dst_q_o  <= '0;
      cnt_q_o  <= '0;
      data_q_o <= '0;
    end else begin
      if (accept_i) begin
        src_q_o <= src_i;
        dst_q_o <= dst_i;
        cnt_q_o <= sel_cnt;
      end else if (step_i) begin
        src_q_o <= ptr_advance(src_q_o);
        dst_q_o <= ptr_advance(dst_q_o);
        cnt_q_o <= cnt_retire(cnt_q_o);
      end
      if (capture_i) data_q_o <= rd_data_i;
    end
  end

endmodule

// File: rtl/mcopy_engine.sv
module mcopy_engine
  import mcopy_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] src_fin_o,
  output logic [ADDR_W-1:0] dst_fin_o,
  output logic [CNT_W-1:0]  cnt_fin_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  mc_state_e         state_w;
  logic              accept_w, capture_w, step_w, finish_w;
  logic              zero_w, last_w;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;

  mcopy_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .zero_cnt_i (zero_w),
    .last_i     (last_w),
    .rd_valid_i (rd_valid_i),
    .state_o    (state_w),
    .accept_o   (accept_w),
    .capture_o  (capture_w),
    .step_o     (step_w),
    .finish_o   (finish_w)
  );

  mcopy_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept_w),
    .capture_i  (capture_w),
    .step_i     (step_w),
    .wide_i     (wide_i),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .cnt_i      (cnt_i),
    .rd_data_i  (rd_data_i),
    .src_q_o    (src_q),
    .dst_q_o    (dst_q),
    .cnt_q_o    (cnt_q),
    .data_q_o   (data_q),
    .zero_cnt_o (zero_w),
    .last_o     (last_w)
  );

  assign busy_o    = (state_w != MC_IDLE);
  assign done_o    = finish_w;
  assign wb_o      = finish_w;
  assign src_fin_o = src_q;
  assign dst_fin_o = dst_q;
  assign cnt_fin_o = cnt_q;
  assign rd_req_o  = (state_w == MC_READ);
  assign rd_addr_o = src_q;
  assign wr_en_o   = step_w;
  assign wr_addr_o = dst_q;
  assign wr_data_o = data_q;

endmodule

// File: rtl/mcopy_checker.sv
module mcopy_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              accept_w,
  input logic              capture_w,
  input logic              zero_w,
  input logic              busy_o,
  input logic              done_o,
  input logic              wb_o,
  input logic [ADDR_W-1:0] src_fin_o,
  input logic [ADDR_W-1:0] dst_fin_o,
  input logic [CNT_W-1:0]  cnt_fin_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_o && wr_en_o));

  assert_write_data_R3: assert property (@(posedge clk) disable iff (rst)
    capture_w |=> (wr_en_o && wr_data_o == $past(rd_data_i)));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> (rd_addr_o == ADDR_W'($past(rd_addr_o) + ADDR_W'(1)) &&
                 wr_addr_o == ADDR_W'($past(wr_addr_o) + ADDR_W'(1))));

  assert_zero_skip_R2: assert property (@(posedge clk) disable iff (rst)
    (accept_w && zero_w) |=> (done_o && !rd_req_o && !wr_en_o));

  assert_done_count_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt_fin_o == '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o && !wb_o);

  assert_fin_stable_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> ($stable(src_fin_o) && $stable(dst_fin_o)));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  assert_busy_excl_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !accept_w);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !rd_req_o && !wr_en_o));

endmodule

bind mcopy_engine mcopy_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .accept_w   (accept_w),
  .capture_w  (capture_w),
  .zero_w     (zero_w),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .wb_o       (wb_o),
  .src_fin_o  (src_fin_o),
  .dst_fin_o  (dst_fin_o),
  .cnt_fin_o  (cnt_fin_o),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .rd_data_i  (rd_data_i),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o)
);

// File: tb/mcopy_engine_bench.sv
module mcopy_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 1024;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [1:0]  lat;
    logic        wide;
    logic [15:0] cnt;
    logic [31:0] src;
    logic [31:0] dst;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 16'h0005, 32'h0000_0010, 32'h0000_0100},
    '{2'd1, 1'b0, 16'h0103, 32'h0000_0020, 32'h0000_0120},
    '{2'd0, 1'b1, 16'h0103, 32'h0000_0000, 32'h0000_0200},
    '{2'd2, 1'b1, 16'h0004, 32'hFFFF_FFFE, 32'h0000_0300},
    '{2'd0, 1'b0, 16'h0100, 32'h0000_0040, 32'h0000_0140},
    '{2'd2, 1'b1, 16'h0001, 32'h0000_0050, 32'h0000_03FF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [31:0] src_i = '0;
  logic [31:0] dst_i = '0;
  logic [15:0] cnt_i = '0;
  logic        busy_o, done_o, wb_o, rd_req_o, wr_en_o;
  logic [31:0] src_fin_o, dst_fin_o, rd_addr_o, wr_addr_o;
  logic [15:0] cnt_fin_o;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic [7:0]  wr_data_o;

  logic [7:0]  mem    [MEM_N];
  logic [7:0]  mem_ref[MEM_N];
  int          cur_lat = 0;
  int          wait_c = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          cycles = 0;
  int          checks = 0;
  int          errors = 0;

  mcopy_engine u_mcopy_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .wide_i(wide_i),
    .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i),
    .busy_o(busy_o), .done_o(done_o), .wb_o(wb_o),
    .src_fin_o(src_fin_o), .dst_fin_o(dst_fin_o), .cnt_fin_o(cnt_fin_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model with programmable read latency
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rd_req_o && !rd_valid_i) begin
      if (wait_c >= cur_lat) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= mem[rd_addr_o[9:0]];
        wait_c     <= 0;
      end else begin
        wait_c <= wait_c + 1;
      end
    end else begin
      rd_valid_i <= 1'b0;
      wait_c     <= 0;
    end
    if (rd_req_o && rd_valid_i) rd_cnt <= rd_cnt + 1;
    if (wr_en_o) begin
      mem[wr_addr_o[9:0]] <= wr_data_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic mem_reset();
    for (int i = 0; i < MEM_N; i++) mem[i] = mem_ref[i];
    rd_cnt = 0;
    wr_cnt = 0;
  endtask

  task automatic run_copy(input logic wide, input logic [15:0] cnt, input logic [31:0] src,
                          input logic [31:0] dst, input int lat, input bit intrude);
    int n;
    int waits;
    int bad;
    n = wide ? int'(cnt) : int'(cnt[7:0]);
    mem_reset();
    cur_lat = lat;
    @(negedge clk);
    start_i = 1'b1; wide_i = wide; cnt_i = cnt; src_i = src; dst_i = dst;
    @(negedge clk);
    start_i = 1'b0;
    if (n > 0) chk(busy_o == 1'b1, "R8 busy after start", 32'(busy_o), 32'd1);
    if (intrude) begin
      @(negedge clk);
      start_i = 1'b1; wide_i = 1'b1; cnt_i = 16'd2; src_i = 32'h70; dst_i = 32'h170;
      @(negedge clk);
      start_i = 1'b0;
    end
    waits = 0;
    while (!done_o && waits < 4000) begin
      @(negedge clk);
      waits++;
    end
    if (n == 0) chk(waits == 0, "R2 zero count completes next cycle", 32'(waits), 32'd0);
    chk(done_o == 1'b1, "R6 done observed", 32'(done_o), 32'd1);
    chk(wb_o == 1'b1, "R6 write-back strobe with done", 32'(wb_o), 32'd1);
    chk(src_fin_o == 32'(src + 32'(n)), "R4 R6 final source pointer", src_fin_o, 32'(src + 32'(n)));
    chk(dst_fin_o == 32'(dst + 32'(n)), "R4 R6 final destination pointer", dst_fin_o, 32'(dst + 32'(n)));
    chk(cnt_fin_o == 16'd0, "R5 final count", 32'(cnt_fin_o), 32'd0);
    chk(wr_cnt == n, "R1 R5 bytes written", 32'(wr_cnt), 32'(n));
    chk(rd_cnt == n, "R5 R7 bytes read", 32'(rd_cnt), 32'(n));
    bad = 0;
    for (int k = 0; k < n; k++) begin
      if (mem[10'(dst + 32'(k))] !== mem_ref[10'(src + 32'(k))]) bad++;
    end
    chk(bad == 0, "R3 copied data matches source", 32'(bad), 32'd0);
    chk(mem[10'(dst + 32'(n))] === mem_ref[10'(dst + 32'(n))], "R5 no byte past the end",
        32'(mem[10'(dst + 32'(n))]), 32'(mem_ref[10'(dst + 32'(n))]));
    @(negedge clk);
    chk(done_o == 1'b0 && wb_o == 1'b0, "R6 done lasts one cycle", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R8 busy clears after done", 32'(busy_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) mem_ref[i] = 8'((i * 37 + 11) ^ (i >> 3));
    mem_reset();
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9 reset state busy/done", {busy_o, done_o}, 32'd0);
    chk(rd_req_o == 1'b0 && wr_en_o == 1'b0, "R9 reset state memory strobes", {rd_req_o, wr_en_o}, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_copy(VECS[v].wide, VECS[v].cnt, VECS[v].src, VECS[v].dst, int'(VECS[v].lat), 1'b0);

    // R8: second start mid-transfer has no effect
    run_copy(1'b1, 16'd6, 32'h60, 32'h160, 1, 1'b1);

    // R9: reset during a transfer
    mem_reset();
    cur_lat = 2;
    @(negedge clk);
    start_i = 1'b1; wide_i = 1'b1; cnt_i = 16'd20; src_i = 32'h80; dst_i = 32'h180;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9 mid-transfer reset clears busy/done", {busy_o, done_o}, 32'd0);
    chk(rd_req_o == 1'b0 && wr_en_o == 1'b0, "R9 mid-transfer reset clears strobes", {rd_req_o, wr_en_o}, 32'd0);
    repeat (2) @(negedge clk);

    // Back-to-back after reset recovery
    run_copy(1'b0, 16'hFF02, 32'h90, 32'h190, 0, 1'b0);

    finish_run();
  end

  initial begin
    wait (cycles >= 100000);
    checks++;
    errors++;
    $display("FAIL watchdog R6 actual=%0d expected=done", cycles);
    finish_run();
  end

endmodule